// File: doc/BRIEF.md
# Interrupt Input Line Latch

This block sits in front of an interrupt priority arbiter. It samples raw interrupt lines every clock, maps each line onto an interrupt ID and a set of CPUs, and keeps two bits of state for every (CPU, ID) pair: a level bit that mirrors the line and a sticky pending bit. It does not decide priority and does not acknowledge interrupts. It only produces the pending and level vectors that the arbiter consumes.

There are two kinds of lines. Shared external lines serve IDs 32 and up and reach every CPU. Private lines serve IDs 0 to 31, one bank of 32 per CPU. A rising line sets pending according to that ID's trigger configuration and, for shared IDs, its per-CPU target mask. A compatibility mode also latches level-triggered IDs that are enabled. Software can set a private ID pending on one CPU. A one-cycle clear strobe removes pending bits, and a set in the same cycle overrides that clear.

Top module: `irq_line_latch`

## Requirements
- R1: While rst_ni is low, and on the first sample after it is released, every bit of pending_o and level_o is 0.
- R2: Shared line ext_line_i[k] maps to ID k+32. level_o bit c*NUM_IDS+k+32 equals the value the line had at the previous clock edge, for every CPU c.
- R3: Private line priv_line_i[c*32+j] maps to ID j on CPU c. It drives level_o bit c*NUM_IDS+j one clock later and touches no other CPU's bits.
- R4: edge_cfg_i[id]=1 marks an ID as edge triggered and 0 as level triggered. A low-to-high change on a shared edge-triggered line sets pending_o bit c*NUM_IDS+id only for the CPUs c with target_i[c*NUM_IDS+id]=1.
- R5: A low-to-high change on a private edge-triggered line sets pending for its own CPU only.
- R6: With compat_i=0, a rising level-triggered line never sets a pending bit.
- R7: With compat_i=1, a rising level-triggered line also sets pending when enabled. A private ID needs enable_i[c*NUM_IDS+id]. A shared ID needs enable_i set for any CPU, and its pending still follows target_i.
- R8: A pending bit stays set after its line falls, until it is cleared.
- R9: sw_set_i sets pending_o bit sw_cpu_i*NUM_IDS+sw_id_i on the next clock. If that bit is already pending, nothing changes.
- R10: clr_i clears pending for ID clr_id_i on every CPU c with clr_mask_i[c]=1. When a line or software set hits the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| compat_i | input | 1 | 1 = also latch enabled level-triggered IDs |
| edge_cfg_i | input | NUM_IDS | Per-ID trigger type, 1 = edge |
| enable_i | input | NUM_CPUS*NUM_IDS | Per-CPU enable, bit c*NUM_IDS+id |
| target_i | input | NUM_CPUS*NUM_IDS | Per-CPU target of shared IDs, bit c*NUM_IDS+id |
| ext_line_i | input | NUM_IDS-32 | Shared lines, line k is ID k+32 |
| priv_line_i | input | NUM_CPUS*32 | Private lines, line c*32+j is ID j of CPU c |
| sw_set_i | input | 1 | Software set-pending strobe |
| sw_cpu_i | input | max(1,clog2(NUM_CPUS)) | CPU of the software set |
| sw_id_i | input | 5 | Private ID of the software set |
| clr_i | input | 1 | Clear strobe |
| clr_id_i | input | clog2(NUM_IDS) | ID to clear |
| clr_mask_i | input | NUM_CPUS | CPUs to clear |
| pending_o | output | NUM_CPUS*NUM_IDS | Pending bits, bit c*NUM_IDS+id |
| level_o | output | NUM_CPUS*NUM_IDS | Level bits, bit c*NUM_IDS+id |

## Verification
Directed cases aim a shared edge at a single-CPU target, so that the target mask is shown to gate each CPU's bit. They drive the same private ID on two CPUs with different enables, which separates the private-enable rule from the shared any-CPU rule. They raise a level-triggered line once with compat_i off and once with it on, which isolates the mode. Clear and set strobes fall on the same bit in one cycle to show the set wins. Random toggling of lines, configuration, software sets and clears then checks the whole pending and level state every cycle against a bench model. That finds wrong index mapping, missed or repeated edges, and leakage between CPUs.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned PRIV_IDS = 32;
  localparam int unsigned PRIV_IW  = 5;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  function automatic int unsigned sel_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_i;
  end

  assign level_o = line_q;
  assign rise_o  = line_i & ~line_q;

  for (genvar i = 0; i < W; i++) begin : g_ast
    AST_RISE_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> level_o[i]); // R4
  end
endmodule

// File: rtl/irq_set_route.sv
module irq_set_route
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned NUM_CPUS = 2,
  localparam int unsigned EXT_N   = NUM_IDS - PRIV_IDS,
  localparam int unsigned PRIV_N  = NUM_CPUS * PRIV_IDS,
  localparam int unsigned FLAT_N  = NUM_CPUS * NUM_IDS
) (
  input  logic              compat_i,
  input  logic [NUM_IDS-1:0] edge_cfg_i,
  input  logic [FLAT_N-1:0] enable_i,
  input  logic [FLAT_N-1:0] target_i,
  input  logic [EXT_N-1:0]  ext_level_i,
  input  logic [EXT_N-1:0]  ext_rise_i,
  input  logic [PRIV_N-1:0] priv_level_i,
  input  logic [PRIV_N-1:0] priv_rise_i,
  output logic [FLAT_N-1:0] set_o,
  output logic [FLAT_N-1:0] level_o
);
  logic [NUM_IDS-1:0] en_any;
  logic               unused_tgt;

  always_comb begin
    en_any = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      en_any = en_any | enable_i[c*NUM_IDS +: NUM_IDS];
  end

  always_comb begin
    unused_tgt = 1'b0;
    for (int c = 0; c < NUM_CPUS; c++)
      unused_tgt = unused_tgt ^ (^target_i[c*NUM_IDS +: PRIV_IDS]);
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar id = 0; id < NUM_IDS; id++) begin : g_id
      localparam int unsigned B = c*NUM_IDS + id;
      if (id < PRIV_IDS) begin : g_priv
        localparam int unsigned P = c*PRIV_IDS + id;
        logic qual;
        assign qual       = (trig_e'(edge_cfg_i[id]) == TRIG_EDGE) || (compat_i && enable_i[B]);
        assign level_o[B] = priv_level_i[P];
        assign set_o[B]   = priv_rise_i[P] && qual;
      end else begin : g_ext
        localparam int unsigned K = id - PRIV_IDS;
        logic qual;
        assign qual       = (trig_e'(edge_cfg_i[id]) == TRIG_EDGE) || (compat_i && en_any[id]);
        assign level_o[B] = ext_level_i[K];
        assign set_o[B]   = ext_rise_i[K] && target_i[B] && qual;
      end
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned NUM_CPUS = 2,
  localparam int unsigned FLAT_N  = NUM_CPUS * NUM_IDS,
  localparam int unsigned CW      = sel_w(NUM_CPUS),
  localparam int unsigned IW      = sel_w(NUM_IDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FLAT_N-1:0]   set_i,
  input  logic                sw_set_i,
  input  logic [CW-1:0]       sw_cpu_i,
  input  logic [PRIV_IW-1:0]  sw_id_i,
  input  logic                clr_i,
  input  logic [IW-1:0]       clr_id_i,
  input  logic [NUM_CPUS-1:0] clr_mask_i,
  output logic [FLAT_N-1:0]   pend_o
);
  logic [FLAT_N-1:0] pend_q, sw_vec, clr_vec;

  always_comb begin
    sw_vec  = '0;
    clr_vec = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int id = 0; id < NUM_IDS; id++) begin
        if (clr_i && clr_mask_i[c] && clr_id_i == IW'(id))
          clr_vec[c*NUM_IDS + id] = 1'b1;
        if (id < PRIV_IDS && sw_set_i && sw_cpu_i == CW'(c) && sw_id_i == PRIV_IW'(id))
          sw_vec[c*NUM_IDS + id] = 1'b1;
      end
    end
  end

  // set beats clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_vec) | set_i | sw_vec;
  end

  assign pend_o = pend_q;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_ast_c
    for (genvar id = 0; id < PRIV_IDS; id++) begin : g_ast_sw
      AST_SW_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_set_i && sw_cpu_i == CW'(c) && sw_id_i == PRIV_IW'(id)) |=> pend_q[c*NUM_IDS+id]); // R9
    end
    for (genvar id = 0; id < NUM_IDS; id++) begin : g_ast_clr
      AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && clr_mask_i[c] && clr_id_i == IW'(id) && !set_i[c*NUM_IDS+id] && !sw_set_i)
        |=> !pend_q[c*NUM_IDS+id]); // R10
      AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[c*NUM_IDS+id] |=> pend_q[c*NUM_IDS+id]); // R10
      AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[c*NUM_IDS+id] && !clr_i) |=> pend_q[c*NUM_IDS+id]); // R8
    end
  end
endmodule

// File: rtl/irq_line_latch.sv
module irq_line_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned NUM_CPUS = 2,
  localparam int unsigned EXT_N   = NUM_IDS - PRIV_IDS,
  localparam int unsigned PRIV_N  = NUM_CPUS * PRIV_IDS,
  localparam int unsigned FLAT_N  = NUM_CPUS * NUM_IDS,
  localparam int unsigned CW      = sel_w(NUM_CPUS),
  localparam int unsigned IW      = sel_w(NUM_IDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                compat_i,
  input  logic [NUM_IDS-1:0]  edge_cfg_i,
  input  logic [FLAT_N-1:0]   enable_i,
  input  logic [FLAT_N-1:0]   target_i,
  input  logic [EXT_N-1:0]    ext_line_i,
  input  logic [PRIV_N-1:0]   priv_line_i,
  input  logic                sw_set_i,
  input  logic [CW-1:0]       sw_cpu_i,
  input  logic [PRIV_IW-1:0]  sw_id_i,
  input  logic                clr_i,
  input  logic [IW-1:0]       clr_id_i,
  input  logic [NUM_CPUS-1:0] clr_mask_i,
  output logic [FLAT_N-1:0]   pending_o,
  output logic [FLAT_N-1:0]   level_o
);
  logic [EXT_N-1:0]  ext_level, ext_rise;
  logic [PRIV_N-1:0] priv_level, priv_rise;
  logic [FLAT_N-1:0] set_vec;

  irq_line_sampler #(.W(EXT_N)) u_ext_smp (
    .clk_i, .rst_ni, .line_i(ext_line_i), .level_o(ext_level), .rise_o(ext_rise)
  );

  irq_line_sampler #(.W(PRIV_N)) u_priv_smp (
    .clk_i, .rst_ni, .line_i(priv_line_i), .level_o(priv_level), .rise_o(priv_rise)
  );

  irq_set_route #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_route (
    .compat_i, .edge_cfg_i, .enable_i, .target_i,
    .ext_level_i(ext_level), .ext_rise_i(ext_rise),
    .priv_level_i(priv_level), .priv_rise_i(priv_rise),
    .set_o(set_vec), .level_o(level_o)
  );

  irq_pend_bank #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_pend (
    .clk_i, .rst_ni, .set_i(set_vec),
    .sw_set_i, .sw_cpu_i, .sw_id_i,
    .clr_i, .clr_id_i, .clr_mask_i,
    .pend_o(pending_o)
  );

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (pending_o == '0 && level_o == '0); // R1
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_ast_c
    for (genvar k = 0; k < EXT_N; k++) begin : g_ast_ext
      AST_EXT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> level_o[c*NUM_IDS+PRIV_IDS+k] == $past(ext_line_i[k])); // R2
      AST_STD_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!compat_i && !edge_cfg_i[PRIV_IDS+k] && !pending_o[c*NUM_IDS+PRIV_IDS+k])
        |=> !pending_o[c*NUM_IDS+PRIV_IDS+k]); // R6
    end
    for (genvar j = 0; j < PRIV_IDS; j++) begin : g_ast_priv
      AST_PRIV_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> level_o[c*NUM_IDS+j] == $past(priv_line_i[c*PRIV_IDS+j])); // R3
    end
  end
endmodule

// File: tb/sim_irq_line_latch.sv
`timescale 1ns/100ps
module sim_irq_line_latch;
  localparam int N  = 64;
  localparam int C  = 2;
  localparam int F  = N*C;
  localparam int E  = N-32;
  localparam int P  = C*32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic compat;
  logic [N-1:0] edge_cfg;
  logic [F-1:0] enable, target;
  logic [E-1:0] ext_line;
  logic [P-1:0] priv_line;
  logic sw_set;
  logic [0:0] sw_cpu;
  logic [4:0] sw_id;
  logic clr;
  logic [5:0] clr_id;
  logic [C-1:0] clr_mask;
  logic [F-1:0] pending, level;

  logic [E-1:0] m_prev_ext;
  logic [P-1:0] m_prev_priv;
  logic [F-1:0] m_pend, m_level, n_pend, n_level;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_line_latch #(.NUM_IDS(N), .NUM_CPUS(C)) u0 (
    .clk_i(clk), .rst_ni, .compat_i(compat), .edge_cfg_i(edge_cfg),
    .enable_i(enable), .target_i(target), .ext_line_i(ext_line),
    .priv_line_i(priv_line), .sw_set_i(sw_set), .sw_cpu_i(sw_cpu),
    .sw_id_i(sw_id), .clr_i(clr), .clr_id_i(clr_id), .clr_mask_i(clr_mask),
    .pending_o(pending), .level_o(level)
  );

  function automatic bit any_en(int id);
    bit r = 0;
    for (int c = 0; c < C; c++) r |= enable[c*N+id];
    return r;
  endfunction

  task automatic model_next();
    for (int c = 0; c < C; c++) begin
      for (int id = 0; id < N; id++) begin
        bit ln, pv, qual, tg, hit_clr, hit_sw;
        int b = c*N + id;
        if (id < 32) begin
          ln = priv_line[c*32+id]; pv = m_prev_priv[c*32+id];
          qual = edge_cfg[id] || (compat && enable[b]); tg = 1;
        end else begin
          ln = ext_line[id-32]; pv = m_prev_ext[id-32];
          qual = edge_cfg[id] || (compat && any_en(id)); tg = target[b];
        end
        hit_clr = clr && clr_mask[c] && (int'(clr_id) == id);
        hit_sw  = sw_set && (int'(sw_cpu) == c) && (int'(sw_id) == id) && id < 32;
        n_level[b] = ln;
        n_pend[b]  = (m_pend[b] && !hit_clr) || (ln && !pv && tg && qual) || hit_sw;
      end
    end
  endtask

  task automatic chk(string tag, logic [F-1:0] act, logic [F-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    model_next();
    @(posedge clk);
    m_pend = n_pend; m_level = n_level;
    m_prev_ext = ext_line; m_prev_priv = priv_line;
    @(negedge clk);
    chk({tag, " pending"}, pending, m_pend);
    chk({tag, " level"}, level, m_level);
    sw_set = 0; clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5e));
    compat = 0; edge_cfg = '0; enable = '0; target = '0;
    ext_line = '0; priv_line = '0; sw_set = 0; sw_cpu = '0; sw_id = '0;
    clr = 0; clr_id = '0; clr_mask = '0;
    m_pend = '0; m_level = '0; m_prev_ext = '0; m_prev_priv = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset pending", pending, '0);
    chk("R1 in reset level", level, '0);
    rst_ni = 1;
    cyc("R1");

    // R4/R2: shared edge ID 40 targeted to CPU1 only
    edge_cfg[40] = 1; target[104] = 1; ext_line[8] = 1;
    cyc("R4");
    chk_bit("R4 cpu1 pend", pending[104], 1'b1);
    chk_bit("R4 cpu0 untargeted", pending[40], 1'b0);
    chk_bit("R2 level cpu0", level[40], 1'b1);
    chk_bit("R2 level cpu1", level[104], 1'b1);
    ext_line[8] = 0;
    cyc("R8");
    chk_bit("R8 sticky", pending[104], 1'b1);
    chk_bit("R2 level fall", level[104], 1'b0);

    // R3/R5: private ID 5 on CPU1
    edge_cfg[5] = 1; priv_line[37] = 1;
    cyc("R5");
    chk_bit("R5 cpu1 pend", pending[69], 1'b1);
    chk_bit("R5 cpu0 clean", pending[5], 1'b0);
    chk_bit("R3 level cpu1", level[69], 1'b1);
    chk_bit("R3 level cpu0", level[5], 1'b0);

    // R6: level-triggered shared ID 50, standard mode
    enable = '1; target[50] = 1; target[114] = 1; ext_line[18] = 1;
    cyc("R6");
    chk_bit("R6 no latch cpu0", pending[50], 1'b0);
    chk_bit("R6 no latch cpu1", pending[114], 1'b0);
    chk_bit("R6 level", level[50], 1'b1);

    // R7: compat mode
    ext_line[18] = 0;
    cyc("R7");
    compat = 1; enable = '0; enable[114] = 1; enable[7] = 1;
    ext_line[18] = 1; priv_line[7] = 1; priv_line[39] = 1;
    cyc("R7");
    chk_bit("R7 shared any-enable cpu0", pending[50], 1'b1);
    chk_bit("R7 shared cpu1", pending[114], 1'b1);
    chk_bit("R7 private enabled", pending[7], 1'b1);
    chk_bit("R7 private disabled", pending[71], 1'b0);
    compat = 0;

    // R9: software set, twice
    sw_set = 1; sw_cpu = 0; sw_id = 3;
    cyc("R9");
    chk_bit("R9 set", pending[3], 1'b1);
    sw_set = 1; sw_cpu = 0; sw_id = 3;
    cyc("R9");
    chk_bit("R9 repeat", pending[3], 1'b1);
    chk_bit("R9 other cpu", pending[67], 1'b0);

    // R10: clears and set-wins
    clr = 1; clr_id = 3; clr_mask = 2'b01;
    cyc("R10");
    chk_bit("R10 cleared", pending[3], 1'b0);
    clr = 1; clr_id = 5; clr_mask = 2'b11; sw_set = 1; sw_cpu = 1; sw_id = 5;
    cyc("R10");
    chk_bit("R10 set wins", pending[69], 1'b1);
    clr = 1; clr_id = 40; clr_mask = 2'b11;
    cyc("R10");
    chk_bit("R10 shared clear", pending[104], 1'b0);

    // random phase: R2 R3 R4 R5 R6 R7 R8 R9 R10 together
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        compat = 1'($urandom);
        edge_cfg = {$urandom, $urandom};
        enable = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
        target = {$urandom, $urandom, $urandom, $urandom};
      end
      for (int k = 0; k < E; k++) if ($urandom % 8 == 0) ext_line[k] = ~ext_line[k];
      for (int k = 0; k < P; k++) if ($urandom % 8 == 0) priv_line[k] = ~priv_line[k];
      sw_set = ($urandom % 10 == 0); sw_cpu = 1'($urandom); sw_id = 5'($urandom);
      clr = ($urandom % 6 == 0); clr_id = 6'($urandom); clr_mask = 2'($urandom);
      cyc("RND R7 R10");
    end
    finish_run();
  end
endmodule